// File: doc/BRIEF.md
# I/O Page Table Translation Engine

This block turns a 32-bit device-side virtual address into a 36-bit physical address by reading one entry from a single-level page table held in memory. A device or bus bridge presents a request with a valid/ready handshake. The engine then forms the entry address from the table base and the page index inside the translation window. It reads that 32-bit entry through a simple read port and checks the entry. It then returns a physical address together with a read-only or read-write permission, or a fault.

On a fault, the engine sends a one-cycle capture strobe to the neighbouring register block. The strobe carries a ready-made status word and the faulting page address, so that block can latch them and raise its interrupt. Only one request is in flight at a time. The engine does not accept a new request until the response has been taken.

Top module: `iopt_walker`

## Requirements
- R1: After reset, `req_ready_o` is 1, and `rsp_valid_o`, `mem_req_o` and `flt_strobe_o` are 0.
- R2: The entry address `mem_addr_o` is `(base_i << 4) + (((vaddr & 0xFFFFF000) & ~{win_page_i, 12'h000}) >> 10)` with its two low bits cleared. `mem_req_o` rises in the cycle after acceptance and stays high with a stable address until a cycle with `mem_rvalid_i` high.
- R3: `mem_rdata_i` is taken as one 32-bit word with bit 31 as the most significant bit of the first byte in memory. A successful translation gives `rsp_paddr_o = {entry[31:8], vaddr[11:0]}`.
- R4: An entry with bit 1 (valid) clear gives `rsp_fault_o = 1`, `rsp_rw_o = 0` and `rsp_paddr_o = 0`.
- R5: A write request (`req_write_i = 1`) to an entry whose bit 2 (writable) is clear gives a fault, even when the entry is valid.
- R6: A valid entry that does not fault gives `rsp_rw_o` equal to entry bit 2: 1 means read-write and 0 means read-only. A read of a non-writable entry does not fault.
- R7: For each faulting request, `flt_strobe_o` is high for exactly one cycle, the first cycle of `rsp_valid_o`. In that cycle `flt_status_o` is 0xC0820000 for a write and 0xC0860000 for a read, and `flt_addr_o` is `vaddr & 0xFFFFF000`. A successful request never raises the strobe.
- R8: `req_ready_o` is 0 from the cycle after acceptance until the cycle after the response handshake. While `rsp_valid_o` is high and `rsp_ready_i` is low, the response stays high and unchanged.
- R9: Entry bit 7 (cacheable), bit 0 (write-as-zero) and bits [6:3] have no effect on the address, the permission or the fault.
- R10: The response appears two cycles after the cycle in which `mem_rvalid_i` is high, whatever the memory latency.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_valid_i | input | 1 | Translation request valid |
| req_ready_o | output | 1 | Engine idle and able to accept a request |
| req_vaddr_i | input | 32 | Device virtual address |
| req_write_i | input | 1 | 1 for a write access, 0 for a read |
| base_i | input | 32 | Page table base register value |
| win_page_i | input | 20 | Window start address bits [31:12] |
| mem_req_o | output | 1 | Entry read request |
| mem_addr_o | output | 36 | Entry byte address |
| mem_rvalid_i | input | 1 | Entry read data valid |
| mem_rdata_i | input | 32 | Entry word |
| rsp_valid_o | output | 1 | Response valid |
| rsp_ready_i | input | 1 | Response accepted |
| rsp_paddr_o | output | 36 | Physical address, 0 on fault |
| rsp_rw_o | output | 1 | 1 means read-write, 0 means read-only |
| rsp_fault_o | output | 1 | Translation fault |
| flt_strobe_o | output | 1 | One-cycle fault capture strobe |
| flt_status_o | output | 32 | Status word to capture |
| flt_addr_o | output | 32 | Faulting page address to capture |

## Verification
The read request is due in the cycle after the accepting edge. The response and any fault strobe are due two edges after the edge that samples `mem_rvalid_i`. `req_ready_o` returns one edge after the response handshake. Each scenario task drives inputs on the falling edge and counts the rising edges between stimulus and result. It samples on the falling edge where the result is due and also on the cycles just before it, so both early and late results are caught. Memory latency and response back-pressure are varied so that the address hold and the response hold are both observed over several cycles.

// File: rtl/iopt_pkg.sv
package iopt_pkg;
  localparam int unsigned PTE_W      = 32;
  localparam int unsigned PTE_PPN_LO = 8;
  localparam int unsigned PTE_V_BIT  = 1;
  localparam int unsigned PTE_WR_BIT = 2;

  localparam logic [31:0] FLT_STAT_BASE = 32'hC082_0000;
  localparam logic [31:0] FLT_STAT_RD   = 32'h0004_0000;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_FETCH = 2'd1,
    ST_CHECK = 2'd2,
    ST_RESP  = 2'd3
  } walk_st_e;
endpackage

// File: rtl/iopt_addr_gen.sv
module iopt_addr_gen #(
  parameter int unsigned VA_W     = 32,
  parameter int unsigned PA_W     = 36,
  parameter int unsigned PG_SHIFT = 12
) (
  input  logic [VA_W-1:0]          vaddr_i,
  input  logic [VA_W-1:0]          base_i,
  input  logic [VA_W-PG_SHIFT-1:0] win_page_i,
  output logic [PA_W-1:0]          pte_addr_o
);
  localparam int unsigned VPN_W  = VA_W - PG_SHIFT;
  localparam int unsigned BASE_SH = PA_W - VA_W;
  localparam int unsigned IDX_PAD = PA_W - VPN_W - 2;

  logic [VPN_W-1:0] vpn_in_win;
  logic [PA_W-1:0]  tbl_base;
  logic [PA_W-1:0]  tbl_off;

  // page index inside window, one 4-byte entry per page
  assign vpn_in_win = vaddr_i[VA_W-1:PG_SHIFT] & ~win_page_i;
  assign tbl_base   = {base_i, {BASE_SH{1'b0}}};
  assign tbl_off    = {{IDX_PAD{1'b0}}, vpn_in_win, 2'b00};
  assign pte_addr_o = tbl_base + tbl_off;
endmodule

// File: rtl/iopt_pte_eval.sv
module iopt_pte_eval
  import iopt_pkg::*;
#(
  parameter int unsigned VA_W     = 32,
  parameter int unsigned PA_W     = 36,
  parameter int unsigned PG_SHIFT = 12
) (
  input  logic [VA_W-1:0]           vaddr_i,
  input  logic                      write_i,
  input  logic [PA_W-PG_SHIFT-1:0]  ppn_i,
  input  logic                      pte_v_i,
  input  logic                      pte_wr_i,
  output logic [PA_W-1:0]           paddr_o,
  output logic                      rw_o,
  output logic                      fault_o,
  output logic [31:0]               status_o,
  output logic [VA_W-1:0]           page_o
);
  logic perm_fault;

  assign perm_fault = write_i & ~pte_wr_i;
  assign fault_o    = ~pte_v_i | perm_fault;
  assign rw_o       = ~fault_o & pte_wr_i;
  assign paddr_o    = fault_o ? '0 : {ppn_i, vaddr_i[PG_SHIFT-1:0]};
  assign status_o   = FLT_STAT_BASE | (write_i ? 32'h0 : FLT_STAT_RD);
  assign page_o     = {vaddr_i[VA_W-1:PG_SHIFT], {PG_SHIFT{1'b0}}};
endmodule

// File: rtl/iopt_ctrl.sv
module iopt_ctrl
  import iopt_pkg::*;
(
  input  logic     clk_i,
  input  logic     rst_ni,
  input  logic     req_valid_i,
  input  logic     mem_rvalid_i,
  input  logic     rsp_ready_i,
  output walk_st_e st_o
);
  walk_st_e st_q, st_d;

  always_comb begin
    st_d = st_q;
    unique case (st_q)
      ST_IDLE:  if (req_valid_i)  st_d = ST_FETCH;
      ST_FETCH: if (mem_rvalid_i) st_d = ST_CHECK;
      ST_CHECK:                   st_d = ST_RESP;
      ST_RESP:  if (rsp_ready_i)  st_d = ST_IDLE;
      default:                    st_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) st_q <= ST_IDLE;
    else         st_q <= st_d;
  end

  assign st_o = st_q;

  p_check_one_cycle_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    st_q == ST_CHECK |=> st_q == ST_RESP);
endmodule

// File: rtl/iopt_walker.sv
module iopt_walker
  import iopt_pkg::*;
#(
  parameter int unsigned VA_W     = 32,
  parameter int unsigned PA_W     = 36,
  parameter int unsigned PG_SHIFT = 12
) (
  input  logic                     clk_i,
  input  logic                     rst_ni,
  input  logic                     req_valid_i,
  output logic                     req_ready_o,
  input  logic [VA_W-1:0]          req_vaddr_i,
  input  logic                     req_write_i,
  input  logic [VA_W-1:0]          base_i,
  input  logic [VA_W-PG_SHIFT-1:0] win_page_i,
  output logic                     mem_req_o,
  output logic [PA_W-1:0]          mem_addr_o,
  input  logic                     mem_rvalid_i,
  input  logic [PTE_W-1:0]         mem_rdata_i,
  output logic                     rsp_valid_o,
  input  logic                     rsp_ready_i,
  output logic [PA_W-1:0]          rsp_paddr_o,
  output logic                     rsp_rw_o,
  output logic                     rsp_fault_o,
  output logic                     flt_strobe_o,
  output logic [31:0]              flt_status_o,
  output logic [VA_W-1:0]          flt_addr_o
);
  localparam int unsigned PPN_W = PA_W - PG_SHIFT;

  walk_st_e         st;
  logic [VA_W-1:0]  vaddr_q;
  logic             wr_q;
  logic [PTE_W-1:0] pte_q;
  logic [PA_W-1:0]  ev_paddr;
  logic             ev_rw, ev_fault;
  logic [31:0]      ev_status;
  logic [VA_W-1:0]  ev_page;
  logic [PA_W-1:0]  paddr_q;
  logic             rw_q, fault_q, stb_q;
  logic [31:0]      status_q;
  logic [VA_W-1:0]  faddr_q;

  iopt_ctrl u_ctrl (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .req_valid_i  (req_valid_i),
    .mem_rvalid_i (mem_rvalid_i),
    .rsp_ready_i  (rsp_ready_i),
    .st_o         (st)
  );

  iopt_addr_gen #(.VA_W(VA_W), .PA_W(PA_W), .PG_SHIFT(PG_SHIFT)) u_addr (
    .vaddr_i    (vaddr_q),
    .base_i     (base_i),
    .win_page_i (win_page_i),
    .pte_addr_o (mem_addr_o)
  );

  iopt_pte_eval #(.VA_W(VA_W), .PA_W(PA_W), .PG_SHIFT(PG_SHIFT)) u_eval (
    .vaddr_i  (vaddr_q),
    .write_i  (wr_q),
    .ppn_i    (pte_q[PTE_W-1 -: PPN_W]),
    .pte_v_i  (pte_q[PTE_V_BIT]),
    .pte_wr_i (pte_q[PTE_WR_BIT]),
    .paddr_o  (ev_paddr),
    .rw_o     (ev_rw),
    .fault_o  (ev_fault),
    .status_o (ev_status),
    .page_o   (ev_page)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      vaddr_q <= '0;
      wr_q    <= 1'b0;
      pte_q   <= '0;
    end else begin
      if (st == ST_IDLE && req_valid_i) begin
        vaddr_q <= req_vaddr_i;
        wr_q    <= req_write_i;
      end
      if (st == ST_FETCH && mem_rvalid_i) pte_q <= mem_rdata_i;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      paddr_q  <= '0;
      rw_q     <= 1'b0;
      fault_q  <= 1'b0;
      stb_q    <= 1'b0;
      status_q <= '0;
      faddr_q  <= '0;
    end else begin
      stb_q <= 1'b0;
      if (st == ST_CHECK) begin
        paddr_q <= ev_paddr;
        rw_q    <= ev_rw;
        fault_q <= ev_fault;
        stb_q   <= ev_fault;
        if (ev_fault) begin
          status_q <= ev_status;
          faddr_q  <= ev_page;
        end
      end
    end
  end

  assign req_ready_o  = (st == ST_IDLE);
  assign mem_req_o    = (st == ST_FETCH);
  assign rsp_valid_o  = (st == ST_RESP);
  assign rsp_paddr_o  = paddr_q;
  assign rsp_rw_o     = rw_q;
  assign rsp_fault_o  = fault_q;
  assign flt_strobe_o = stb_q;
  assign flt_status_o = status_q;
  assign flt_addr_o   = faddr_q;

  p_addr_hold_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_req_o && !mem_rvalid_i |=> mem_req_o && $stable(mem_addr_o));
  p_fault_no_perm_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rsp_valid_o && rsp_fault_o |-> !rsp_rw_o && rsp_paddr_o == '0);
  p_write_needs_rw_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rsp_valid_o && wr_q && !rsp_fault_o |-> rsp_rw_o);
  p_strobe_pulse_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    flt_strobe_o |=> !flt_strobe_o);
  p_strobe_fault_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    flt_strobe_o |-> rsp_valid_o && rsp_fault_o);
  p_rsp_hold_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rsp_valid_o && !rsp_ready_i |=> rsp_valid_o && $stable(rsp_paddr_o)
      && $stable(rsp_rw_o) && $stable(rsp_fault_o));
  p_busy_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mem_req_o || rsp_valid_o) |-> !req_ready_o);
  p_pte_held_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    st == ST_RESP |-> $stable(pte_q));
endmodule

// File: tb/iopt_walker_tb.sv
module iopt_walker_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0, req_write = 1'b0;
  logic        req_ready;
  logic [31:0] req_vaddr = '0, base = '0;
  logic [19:0] win_page = '0;
  logic        mem_req, mem_rvalid = 1'b0;
  logic [35:0] mem_addr;
  logic [31:0] mem_rdata = '0;
  logic        rsp_valid, rsp_ready = 1'b0, rsp_rw, rsp_fault;
  logic [35:0] rsp_paddr;
  logic        flt_strobe;
  logic [31:0] flt_status, flt_addr;
  int checks = 0, errors = 0;
  bit done = 0;

  always #4 clk = ~clk;

  iopt_walker u_dut (
    .clk_i(clk), .rst_ni(rst_n),
    .req_valid_i(req_valid), .req_ready_o(req_ready),
    .req_vaddr_i(req_vaddr), .req_write_i(req_write),
    .base_i(base), .win_page_i(win_page),
    .mem_req_o(mem_req), .mem_addr_o(mem_addr),
    .mem_rvalid_i(mem_rvalid), .mem_rdata_i(mem_rdata),
    .rsp_valid_o(rsp_valid), .rsp_ready_i(rsp_ready),
    .rsp_paddr_o(rsp_paddr), .rsp_rw_o(rsp_rw), .rsp_fault_o(rsp_fault),
    .flt_strobe_o(flt_strobe), .flt_status_o(flt_status), .flt_addr_o(flt_addr)
  );

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  // one full translation; inputs move on falling edges, outputs sampled there
  task automatic xact(input logic [31:0] va, input logic wr, input logic [31:0] b,
                      input logic [19:0] w, input logic [31:0] pte,
                      input int lat, input int hold);
    logic [35:0] e_addr, e_pa;
    logic        e_fault, e_rw;
    logic [31:0] e_stat;
    e_addr = {b, 4'h0} + (((({4'h0, va & 32'hFFFF_F000}) & {4'h0, ~{w, 12'h000}}) >> 10) & ~36'h3);
    e_fault = !pte[1] || (wr && !pte[2]);
    e_rw    = !e_fault && pte[2];
    e_pa    = e_fault ? 36'h0 : (({4'h0, pte & 32'hFFFF_FF00}) << 4) + {24'h0, va[11:0]};
    e_stat  = wr ? 32'hC082_0000 : 32'hC086_0000;
    @(negedge clk);
    base = b; win_page = w; req_vaddr = va; req_write = wr; req_valid = 1'b1;
    chk("R8 ready before accept", req_ready, 1);
    @(negedge clk);
    req_valid = 1'b0;
    chk("R8 ready low after accept", req_ready, 0);
    chk("R2 mem_req", mem_req, 1);
    chk("R2 entry address", mem_addr, e_addr);
    for (int i = 0; i < lat; i++) begin
      @(negedge clk);
      chk("R2 mem_req held", mem_req, 1);
      chk("R2 address held", mem_addr, e_addr);
    end
    mem_rvalid = 1'b1; mem_rdata = pte;
    @(negedge clk);
    mem_rvalid = 1'b0; mem_rdata = 32'hDEAD_BEEF;
    chk("R10 no response yet", rsp_valid, 0);
    chk("R2 mem_req dropped", mem_req, 0);
    @(negedge clk);
    chk("R10 response due", rsp_valid, 1);
    chk("R3 paddr", rsp_paddr, e_pa);
    chk("R6 perm", rsp_rw, e_rw);
    chk("R4 R5 fault", rsp_fault, e_fault);
    chk("R7 strobe", flt_strobe, e_fault);
    if (e_fault) begin
      chk("R7 status", flt_status, e_stat);
      chk("R7 addr", flt_addr, va & 32'hFFFF_F000);
    end
    for (int i = 0; i < hold; i++) begin
      @(negedge clk);
      chk("R8 rsp held", rsp_valid, 1);
      chk("R8 paddr held", rsp_paddr, e_pa);
      chk("R8 ready low", req_ready, 0);
      chk("R7 strobe single", flt_strobe, 0);
    end
    rsp_ready = 1'b1;
    @(negedge clk);
    rsp_ready = 1'b0;
    chk("R8 rsp done", rsp_valid, 0);
    chk("R8 ready back", req_ready, 1);
    chk("R7 strobe quiet", flt_strobe, 0);
  endtask

  task automatic t_reset;   // R1
    chk("R1 ready", req_ready, 1);
    chk("R1 rsp_valid", rsp_valid, 0);
    chk("R1 mem_req", mem_req, 0);
    chk("R1 strobe", flt_strobe, 0);
  endtask

  task automatic t_read_rw;     xact(32'hFF12_3ABC, 0, 32'h0123_4400, 20'hFF000, 32'h00AB_CD06, 0, 0); endtask
  task automatic t_read_ro;     xact(32'hFF00_0FFF, 0, 32'h0000_0400, 20'hFF000, 32'hFFFF_FF02, 2, 0); endtask
  task automatic t_write_ok;    xact(32'hF800_1004, 1, 32'h0765_4C00, 20'hF8000, 32'h1234_5606, 1, 1); endtask
  task automatic t_invalid_rd;  xact(32'hFF45_6123, 0, 32'h0100_0000, 20'hFF000, 32'h0ABC_DE04, 0, 0); endtask  // R4 R7
  task automatic t_wr_prot;     xact(32'hFE7F_F800, 1, 32'h0200_0000, 20'hFE000, 32'h0555_5502, 3, 0); endtask  // R5 R7
  task automatic t_invalid_wr;  xact(32'h8765_4321, 1, 32'h0000_0000, 20'h80000, 32'h0000_0000, 0, 2); endtask
  task automatic t_window;      xact(32'hC3FF_F010, 0, 32'h0040_0000, 20'hC0000, 32'h0F0F_0F06, 0, 0); endtask  // R2
  task automatic t_ignored;     xact(32'hFF12_3ABC, 0, 32'h0123_4400, 20'hFF000, 32'h00AB_CDFF, 0, 0); endtask  // R9
  task automatic t_ignored_ro;  xact(32'hFF12_3ABC, 0, 32'h0123_4400, 20'hFF000, 32'h00AB_CDFB, 1, 0); endtask  // R9
  task automatic t_backpress;   xact(32'hF000_0000, 0, 32'h07FF_FC00, 20'hF0000, 32'hFFFF_FF06, 4, 5); endtask  // R8 R10

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_read_rw();
    t_read_ro();
    t_write_ok();
    t_invalid_rd();
    t_wr_prot();
    t_invalid_wr();
    t_window();
    t_ignored();
    t_ignored_ro();
    t_backpress();
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule